// File: doc/BRIEF.md
# Dual-Output Pixel Stream Merger

A linear image sensor shifts a scan line out on two channels: one channel carries the odd-numbered elements and the other carries the even-numbered elements. After each channel has been digitised, this block merges the two sample streams back into a single stream in line order. It numbers every element by its position in the line and marks each one as a shielded dark reference element, a dummy element or an imaging pixel. With the default parameters a line holds 22 dark elements, then 2 dummies, then 5000 imaging pixels, then 2 more dummies.

The block accepts either sensor timing without a mode setting. In the staggered timing the odd and even samples arrive in different cycles. In the paired timing both samples of a pair arrive in the same cycle: the odd sample goes out first and the even sample waits one cycle in a single holding register. A strobe marks the start of every line. A sample that breaks the odd/even alternation is dropped and sets a fault flag, which stays set until reset.

Top module: `pxm_merge`

## Requirements
- R1: After reset `out_vld`, `out_eol` and `seq_err` are 0. Samples that arrive before the first `line_start` produce no output.
- R2: `line_start` restarts the line, so that the next accepted sample is position 1. It drops any pending odd sample or held even sample. Samples in the `line_start` cycle are ignored and `out_vld` is 0 in the following cycle.
- R3: In the staggered timing, an odd sample is output on the cycle after it arrives and its even partner is output on the cycle after that partner arrives. The data is unchanged.
- R4: In the paired timing (both samples valid in one cycle) the odd sample is output on the next cycle and the even sample on the cycle after, with the data unchanged.
- R5: `out_pos` is the 1-based position of the element in its line and rises by exactly 1 per output element. Odd positions come from the odd channel.
- R6: `out_tag` is 0 (dark) for positions 1..22, 1 (dummy) for positions 23..24 and 5025..5026, and 2 (imaging) for positions 25..5024. Imaging pixel k therefore sits at position 24+k, and odd k comes from the odd channel.
- R7: `out_eol` is 1 together with the element at the last position (5026) and 0 for every other element.
- R8: Once the last element of a line has been output, further samples are ignored and raise no fault until the next `line_start`.
- R9: An even sample with no pending odd sample, or an odd sample while an even sample is still expected, is dropped and sets `seq_err`. A pending odd sample stays pending.
- R10: A sample that arrives in the cycle in which a held even sample is being output is dropped and sets `seq_err`. The held sample still goes out with its correct position.
- R11: `seq_err` stays 1 across `line_start` and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start-of-line strobe |
| odd_vld | input | 1 | Odd-channel sample valid |
| odd_data | input | DATA_W (12) | Odd-channel sample |
| even_vld | input | 1 | Even-channel sample valid |
| even_data | input | DATA_W (12) | Even-channel sample |
| out_vld | output | 1 | Merged element valid |
| out_data | output | DATA_W (12) | Merged element sample |
| out_tag | output | 2 | 0 dark, 1 dummy, 2 imaging |
| out_pos | output | POS_W (13) | 1-based element position in the line |
| out_eol | output | 1 | Last element of the line |
| seq_err | output | 1 | Sticky odd/even order fault |

## Verification
Every output is registered once. A sample accepted at a clock edge therefore appears on the outputs right after that edge, except that the even half of a pair appears one edge later. A fault flag set by a bad sample is visible right after the edge that captured it. The bench applies each stimulus cycle, waits for the rising edge and then for the falling edge, and compares the outputs there against values computed from the position. Each idle or rejected cycle is checked for a low `out_vld` in the same way, so an output that arrives early or late is caught as a mismatch.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
  typedef enum logic [1:0] {
    TAG_DARK  = 2'd0,
    TAG_DUMMY = 2'd1,
    TAG_PIXEL = 2'd2
  } pxm_tag_e;
endpackage

// File: rtl/pxm_pair_order.sv
// Restores odd/even order from the two channels; one-entry hold for paired arrival.
module pxm_pair_order #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              line_done,
  input  logic              odd_vld,
  input  logic [DATA_W-1:0] odd_data,
  input  logic              even_vld,
  input  logic [DATA_W-1:0] even_data,
  output logic              emit_vld,
  output logic [DATA_W-1:0] emit_data,
  output logic              seq_err
);
  logic              pend_q, pend_d;
  logic              hold_q, hold_d;
  logic [DATA_W-1:0] hold_data_q, hold_data_d;
  logic              err_q, err_set;

  always_comb begin
    emit_vld    = 1'b0;
    emit_data   = odd_data;
    pend_d      = pend_q;
    hold_d      = 1'b0;
    hold_data_d = hold_data_q;
    err_set     = 1'b0;
    if (line_start) begin
      pend_d = 1'b0;
    end else if (hold_q) begin
      emit_vld  = 1'b1;
      emit_data = hold_data_q;
      err_set   = odd_vld | even_vld;
    end else if (!line_done) begin
      if (!pend_q) begin
        if (odd_vld) begin
          emit_vld  = 1'b1;
          emit_data = odd_data;
          if (even_vld) begin
            hold_d      = 1'b1;
            hold_data_d = even_data;
          end else begin
            pend_d = 1'b1;
          end
        end else if (even_vld) begin
          err_set = 1'b1;
        end
      end else begin
        if (odd_vld) begin
          err_set = 1'b1;
        end else if (even_vld) begin
          emit_vld  = 1'b1;
          emit_data = even_data;
          pend_d    = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      hold_q      <= 1'b0;
      hold_data_q <= '0;
      err_q       <= 1'b0;
    end else begin
      pend_q      <= pend_d;
      hold_q      <= hold_d;
      hold_data_q <= hold_data_d;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign seq_err = err_q;
endmodule

// File: rtl/pxm_line_tagger.sv
// Counts elements in the line, tags them by position and registers the output.
module pxm_line_tagger
  import pxm_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int OB_N    = 22,
  parameter int LEAD_N  = 2,
  parameter int VALID_N = 5000,
  parameter int TRAIL_N = 2,
  parameter int POS_W   = $clog2(OB_N + LEAD_N + VALID_N + TRAIL_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              emit_vld,
  input  logic [DATA_W-1:0] emit_data,
  output logic              line_done,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output pxm_tag_e          out_tag,
  output logic [POS_W-1:0]  out_pos,
  output logic              out_eol
);
  localparam int DARK_END = OB_N;
  localparam int LEAD_END = OB_N + LEAD_N;
  localparam int PIX_END  = LEAD_END + VALID_N;
  localparam int TOTAL_N  = PIX_END + TRAIL_N;
  localparam logic [POS_W-1:0] TOTAL_P = POS_W'(TOTAL_N);

  logic [POS_W-1:0] cnt_q;
  logic [POS_W-1:0] next_pos;
  pxm_tag_e         next_tag;

  assign next_pos  = cnt_q + 1'b1;
  assign line_done = (cnt_q == TOTAL_P);

  always_comb begin
    if (int'(next_pos) <= DARK_END)      next_tag = TAG_DARK;
    else if (int'(next_pos) <= LEAD_END) next_tag = TAG_DUMMY;
    else if (int'(next_pos) <= PIX_END)  next_tag = TAG_PIXEL;
    else                                 next_tag = TAG_DUMMY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= TOTAL_P;
      out_vld  <= 1'b0;
      out_data <= '0;
      out_tag  <= TAG_DARK;
      out_pos  <= '0;
      out_eol  <= 1'b0;
    end else if (line_start) begin
      cnt_q   <= '0;
      out_vld <= 1'b0;
      out_eol <= 1'b0;
    end else if (emit_vld) begin
      cnt_q    <= next_pos;
      out_vld  <= 1'b1;
      out_data <= emit_data;
      out_tag  <= next_tag;
      out_pos  <= next_pos;
      out_eol  <= (next_pos == TOTAL_P);
    end else begin
      out_vld <= 1'b0;
      out_eol <= 1'b0;
    end
  end
endmodule

// File: rtl/pxm_merge.sv
module pxm_merge
  import pxm_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int OB_N    = 22,
  parameter int LEAD_N  = 2,
  parameter int VALID_N = 5000,
  parameter int TRAIL_N = 2,
  parameter int POS_W   = $clog2(OB_N + LEAD_N + VALID_N + TRAIL_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              odd_vld,
  input  logic [DATA_W-1:0] odd_data,
  input  logic              even_vld,
  input  logic [DATA_W-1:0] even_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        out_tag,
  output logic [POS_W-1:0]  out_pos,
  output logic              out_eol,
  output logic              seq_err
);
  logic              emit_vld;
  logic [DATA_W-1:0] emit_data;
  logic              line_done;
  pxm_tag_e          tag_w;

  pxm_pair_order #(.DATA_W(DATA_W)) u_order (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .line_done  (line_done),
    .odd_vld    (odd_vld),
    .odd_data   (odd_data),
    .even_vld   (even_vld),
    .even_data  (even_data),
    .emit_vld   (emit_vld),
    .emit_data  (emit_data),
    .seq_err    (seq_err)
  );

  pxm_line_tagger #(
    .DATA_W  (DATA_W),
    .OB_N    (OB_N),
    .LEAD_N  (LEAD_N),
    .VALID_N (VALID_N),
    .TRAIL_N (TRAIL_N),
    .POS_W   (POS_W)
  ) u_tag (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .emit_vld   (emit_vld),
    .emit_data  (emit_data),
    .line_done  (line_done),
    .out_vld    (out_vld),
    .out_data   (out_data),
    .out_tag    (tag_w),
    .out_pos    (out_pos),
    .out_eol    (out_eol)
  );

  assign out_tag = tag_w;
endmodule

// File: rtl/pxm_merge_chk.sv
module pxm_merge_chk #(
  parameter int OB_N    = 22,
  parameter int TOTAL_N = 5026,
  parameter int POS_W   = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             line_start,
  input logic             out_vld,
  input logic [1:0]       out_tag,
  input logic [POS_W-1:0] out_pos,
  input logic             out_eol,
  input logic             seq_err
);
  // R5: consecutive elements of a line step the position by one
  a_r5_pos_step: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_eol && !line_start) |=> (!out_vld || out_pos == $past(out_pos) + 1'b1));

  // R7: end of line only on the last position
  a_r7_eol_last: assert property (@(posedge clk) disable iff (rst)
    out_eol |-> (out_vld && out_pos == POS_W'(TOTAL_N)));

  // R8: nothing follows the last element
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_eol) |=> !out_vld);

  // R2: the cycle after a line start carries no element
  a_r2_start_quiet: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !out_vld);

  // R6: leading positions are dark elements
  a_r6_dark_tag: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_pos <= POS_W'(OB_N)) |-> out_tag == 2'd0);

  // R11: fault flag never clears without reset
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);
endmodule

bind pxm_merge pxm_merge_chk #(
  .OB_N    (OB_N),
  .TOTAL_N (OB_N + LEAD_N + VALID_N + TRAIL_N),
  .POS_W   (POS_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_start (line_start),
  .out_vld    (out_vld),
  .out_tag    (out_tag),
  .out_pos    (out_pos),
  .out_eol    (out_eol),
  .seq_err    (seq_err)
);

// File: tb/sim_pxm_merge.sv
module sim_pxm_merge;
  localparam int DW  = 12;
  localparam int OB  = 22;
  localparam int LD  = 2;
  localparam int VN  = 5000;
  localparam int TR  = 2;
  localparam int TOT = OB + LD + VN + TR;
  localparam int PW  = 13;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          line_start = 1'b0;
  logic          odd_vld = 1'b0, even_vld = 1'b0;
  logic [DW-1:0] odd_data = '0, even_data = '0;
  logic          out_vld, out_eol, seq_err;
  logic [DW-1:0] out_data;
  logic [1:0]    out_tag;
  logic [PW-1:0] out_pos;

  pxm_merge u0 (
    .clk(clk), .rst(rst), .line_start(line_start),
    .odd_vld(odd_vld), .odd_data(odd_data),
    .even_vld(even_vld), .even_data(even_data),
    .out_vld(out_vld), .out_data(out_data), .out_tag(out_tag),
    .out_pos(out_pos), .out_eol(out_eol), .seq_err(seq_err)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tag_of(int p);
    if (p <= OB) return 0;
    if (p <= OB + LD) return 1;
    if (p <= OB + LD + VN) return 2;
    return 1;
  endfunction

  function automatic logic [DW-1:0] dat_of(int p, int ln);
    return DW'(p * 37 + ln * 101 + 5);
  endfunction

  // Apply one cycle of inputs; return just after the falling edge that follows.
  task automatic step(bit ov, bit ev, bit ls, int op, int ep, int ln);
    odd_vld    = ov;
    even_vld   = ev;
    line_start = ls;
    odd_data   = dat_of(op, ln);
    even_data  = dat_of(ep, ln);
    @(posedge clk);
    @(negedge clk);
    odd_vld    = 1'b0;
    even_vld   = 1'b0;
    line_start = 1'b0;
  endtask

  task automatic expect_px(string req, int p, int ln);
    chk({req, " valid"}, int'(out_vld), 1);
    chk({req, " data"}, int'(out_data), int'(dat_of(p, ln)));
    chk("R5 position", int'(out_pos), p);
    chk("R6 tag", int'(out_tag), tag_of(p));
    chk("R7 end of line", int'(out_eol), (p == TOT) ? 1 : 0);
  endtask

  task automatic expect_none(string req);
    chk(req, int'(out_vld), 0);
  endtask

  task automatic idle_gaps(int maxgap, string req);
    int g = int'($urandom_range(maxgap, 0));
    for (int i = 0; i < g; i++) begin
      step(0, 0, 0, 0, 0, 0);
      expect_none(req);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // mode 0 staggered, 1 paired, 2 random mix per pair
  task automatic run_line(int ln, int mode);
    step(0, 0, 1, 0, 0, ln);
    expect_none("R2 start cycle");
    for (int p = 1; p <= TOT; p += 2) begin
      bit paired = (mode == 1) || (mode == 2 && $urandom_range(1, 0) == 1);
      if (paired) begin
        step(1, 1, 0, p, p + 1, ln);
        expect_px("R4 odd first", p, ln);
        step(0, 0, 0, 0, 0, ln);
        expect_px("R4 even second", p + 1, ln);
        idle_gaps(2, "R4 idle");
      end else begin
        step(1, 0, 0, p, 0, ln);
        expect_px("R3 odd", p, ln);
        idle_gaps(2, "R3 idle");
        step(0, 1, 0, 0, p + 1, ln);
        expect_px("R3 even", p + 1, ln);
        idle_gaps(2, "R3 idle");
      end
    end
    chk("R9 no false fault", int'(seq_err), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    do_reset();
    chk("R1 reset valid", int'(out_vld), 0);
    chk("R1 reset eol", int'(out_eol), 0);
    chk("R1 reset fault", int'(seq_err), 0);
    step(1, 0, 0, 1, 0, 0);
    expect_none("R1 sample before first line start");
    chk("R1 no fault before start", int'(seq_err), 0);

    // R2: sample in the line_start cycle is ignored, next odd is position 1
    step(1, 0, 1, 9, 0, 1);
    expect_none("R2 sample with line_start");
    step(1, 0, 0, 1, 0, 1);
    expect_px("R2 first after start", 1, 1);
    step(0, 1, 0, 0, 2, 1);
    expect_px("R3 even", 2, 1);

    run_line(2, 0);
    step(1, 0, 0, 1, 0, 2);
    expect_none("R8 sample after last element");
    step(0, 1, 0, 0, 2, 2);
    expect_none("R8 sample after last element");
    chk("R8 no fault after line", int'(seq_err), 0);

    run_line(3, 1);
    run_line(4, 2);

    // R2: held even dropped by line_start
    step(0, 0, 1, 0, 0, 5);
    step(1, 1, 0, 1, 2, 5);
    expect_px("R4 odd first", 1, 5);
    step(0, 0, 1, 0, 0, 5);
    expect_none("R2 held sample dropped");
    step(1, 0, 0, 1, 0, 5);
    expect_px("R2 restart at 1", 1, 5);
    chk("R2 no fault", int'(seq_err), 0);

    // R9: even with nothing pending
    do_reset();
    step(0, 0, 1, 0, 0, 6);
    step(0, 1, 0, 0, 2, 6);
    expect_none("R9 lone even dropped");
    chk("R9 lone even fault", int'(seq_err), 1);
    step(0, 0, 1, 0, 0, 6);
    chk("R11 fault kept over line_start", int'(seq_err), 1);
    step(1, 0, 0, 1, 0, 6);
    expect_px("R9 line continues", 1, 6);
    do_reset();
    chk("R11 fault cleared by reset", int'(seq_err), 0);

    // R9: second odd while even expected
    step(0, 0, 1, 0, 0, 7);
    step(1, 0, 0, 1, 0, 7);
    expect_px("R3 odd", 1, 7);
    step(1, 0, 0, 3, 0, 7);
    expect_none("R9 extra odd dropped");
    chk("R9 extra odd fault", int'(seq_err), 1);
    step(0, 1, 0, 0, 2, 7);
    expect_px("R9 pending odd kept", 2, 7);

    // R10: arrival during hold drain
    do_reset();
    step(0, 0, 1, 0, 0, 8);
    step(1, 1, 0, 1, 2, 8);
    expect_px("R4 odd first", 1, 8);
    step(1, 0, 0, 3, 0, 8);
    expect_px("R10 held even still out", 2, 8);
    chk("R10 drain arrival fault", int'(seq_err), 1);
    step(0, 0, 0, 0, 0, 8);
    expect_none("R10 drain arrival dropped");
    step(1, 0, 0, 3, 0, 8);
    expect_px("R10 line continues", 3, 8);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule